// File: doc/BRIEF.md
# Dual-Clock FIFO with Gray-Coded Pointer Crossing

This block carries data words from a producer running on one clock to a consumer running on an unrelated clock. Each side keeps a binary pointer that is one bit wider than the address, so a full FIFO and an empty FIFO are told apart. Each side also publishes a registered Gray-code copy of its pointer to the other side. The receiving side passes that copy through a two-flop synchronizer and converts it back to binary. The full flag comes from subtracting the synchronized read pointer from the local write pointer, in the write domain. The empty flag comes from subtracting the local read pointer from the synchronized write pointer, in the read domain.

The storage is a memory array with a registered read port, so read data appears one read clock after the read is accepted. `rd_valid` marks that cycle. A write is accepted only when `wr_req` is high and `wr_full` is low. A read is accepted only when `rd_req` is high and `rd_empty` is low. Each pointer is held back by one extra clock of its own domain before it is Gray-encoded and sent across. A word therefore settles in memory well before the reader can see that it exists.

Both flags are pessimistic. A synchronized pointer lags the true pointer, and it may skip values when one clock is much faster than the other. Every sampled Gray value is still a real past pointer, so the FIFO can never overflow or underflow.

Top module: `cdc_fifo`

## Requirements
- R1: While both resets are low, `rd_empty` is 1, `wr_full` is 0 and `rd_valid` is 0.
- R2: Words leave on `rd_data` in exactly the order in which they were accepted on `wr_data`, with no loss and no duplication.
- R3: With the reader idle and settled, `wr_full` is 1 exactly when the accepted writes minus the accepted reads equal 16, which is the capacity for the default address width of 4.
- R4: A write request made while `wr_full` is 1 changes nothing: the write pointer holds, and the offered word never appears on the read side.
- R5: A read request made while `rd_empty` is 1 changes nothing: the read pointer holds, and `rd_valid` stays 0 on the next read clock.
- R6: `rd_valid` is 1 on the read clock edge right after an accepted read, and 0 after any other read cycle. `rd_data` carries the word on that same edge.
- R7: After one write into an empty, settled FIFO, `rd_empty` is still 1 at the first read-clock sample and falls within 8 read clocks. After one read from a full FIFO, `wr_full` is still 1 at the first write-clock sample and falls within 12 write clocks.
- R8: Each Gray pointer copy that crosses a clock boundary changes in at most one bit per clock of its own domain.
- R9: Under any mix of request patterns, the accepted writes minus the accepted reads stays between 0 and 16, and after a drain the two counts are equal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst_n | input | 1 | Write-domain asynchronous reset, active low |
| wr_req | input | 1 | Producer asks to store `wr_data` |
| wr_data | input | DW | Word to store |
| wr_full | output | 1 | No free entry as seen from the write side |
| rd_clk | input | 1 | Read-domain clock |
| rd_rst_n | input | 1 | Read-domain asynchronous reset, active low |
| rd_req | input | 1 | Consumer asks for the next word |
| rd_empty | output | 1 | No stored word as seen from the read side |
| rd_valid | output | 1 | `rd_data` holds the word from the previous accepted read |
| rd_data | output | DW | Word read from storage |

## Verification
The assertions check, on every clock, that pointers hold while the matching flag is set, that `rd_valid` follows an accepted read by exactly one read clock, and that each Gray copy moves by at most one bit. The bench's scenarios show the things that need a model of the stream. These are word order and integrity, the exact cycle at which full rises when the FIFO is filled, the bounded but nonzero delay before each flag releases across the clock boundary, and the occupancy bound under producer-heavy, consumer-heavy and saturated traffic.

// File: rtl/cdc_fifo_pkg.sv
package cdc_fifo_pkg;

    // Widest pointer the helper functions handle; callers size-cast in and out.
    localparam int PTR_MAX = 16;

    function automatic logic [PTR_MAX-1:0] bin_to_gray(input logic [PTR_MAX-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [PTR_MAX-1:0] gray_to_bin(input logic [PTR_MAX-1:0] g);
        logic [PTR_MAX-1:0] b;
        b[PTR_MAX-1] = g[PTR_MAX-1];
        for (int i = PTR_MAX - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/cdc_fifo_sync.sv
module cdc_fifo_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= '0;
            end
        end else begin
            stage_q[0] <= din;
            for (int i = 1; i < STAGES; i++) begin
                stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/cdc_fifo_wside.sv
module cdc_fifo_wside
    import cdc_fifo_pkg::*;
#(
    parameter int PW    = 5,
    parameter int DEPTH = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic [PW-1:0] rgray_sync,
    output logic          full,
    output logic          wen,
    output logic [PW-1:0] ptr,
    output logic [PW-1:0] gray
);
    localparam logic [PW-1:0] FULL_LVL = PW'(DEPTH);

    typedef struct packed {
        logic [PW-1:0] ptr;
        logic [PW-1:0] ptr_dly;
        logic [PW-1:0] gray;
    } wst_t;

    wst_t          st_d, st_q;
    logic [PW-1:0] rptr_sync;
    logic [PW-1:0] level;

    always_comb begin
        rptr_sync = PW'(gray_to_bin(PTR_MAX'(rgray_sync)));
        level     = st_q.ptr - rptr_sync;
        full      = (level == FULL_LVL);
        wen       = req & ~full;

        st_d = st_q;
        if (wen) begin
            st_d.ptr = st_q.ptr + PW'(1);
        end
        // one extra write clock before the pointer is published
        st_d.ptr_dly = st_q.ptr;
        st_d.gray    = PW'(bin_to_gray(PTR_MAX'(st_q.ptr_dly)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ptr  = st_q.ptr;
    assign gray = st_q.gray;
endmodule

// File: rtl/cdc_fifo_rside.sv
module cdc_fifo_rside
    import cdc_fifo_pkg::*;
#(
    parameter int PW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic [PW-1:0] wgray_sync,
    output logic          empty,
    output logic          ren,
    output logic          valid,
    output logic [PW-1:0] ptr,
    output logic [PW-1:0] gray
);
    typedef struct packed {
        logic [PW-1:0] ptr;
        logic [PW-1:0] ptr_dly;
        logic [PW-1:0] gray;
        logic          valid;
    } rst_t;

    rst_t          st_d, st_q;
    logic [PW-1:0] wptr_sync;
    logic [PW-1:0] level;

    always_comb begin
        wptr_sync = PW'(gray_to_bin(PTR_MAX'(wgray_sync)));
        level     = wptr_sync - st_q.ptr;
        empty     = (level == '0);
        ren       = req & ~empty;

        st_d = st_q;
        if (ren) begin
            st_d.ptr = st_q.ptr + PW'(1);
        end
        st_d.valid   = ren;
        // one extra read clock before the pointer is published
        st_d.ptr_dly = st_q.ptr;
        st_d.gray    = PW'(bin_to_gray(PTR_MAX'(st_q.ptr_dly)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ptr   = st_q.ptr;
    assign gray  = st_q.gray;
    assign valid = st_q.valid;
endmodule

// File: rtl/cdc_fifo_mem.sv
module cdc_fifo_mem #(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          rclk,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] store_q [DEPTH];
    logic [DW-1:0] rdata_q;

    always_ff @(posedge wclk) begin
        if (we) begin
            store_q[waddr] <= wdata;
        end
    end

    always_ff @(posedge rclk) begin
        if (re) begin
            rdata_q <= store_q[raddr];
        end
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/cdc_fifo.sv
module cdc_fifo #(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input  logic          wr_clk,
    input  logic          wr_rst_n,
    input  logic          wr_req,
    input  logic [DW-1:0] wr_data,
    output logic          wr_full,
    input  logic          rd_clk,
    input  logic          rd_rst_n,
    input  logic          rd_req,
    output logic          rd_empty,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data
);
    localparam int PW    = AW + 1;
    localparam int DEPTH = 1 << AW;

    logic [PW-1:0] wr_ptr, wr_gray, rd_ptr, rd_gray;
    logic [PW-1:0] wgray_at_rd, rgray_at_wr;
    logic          wr_en, rd_en;

    cdc_fifo_sync #(.W(PW), .STAGES(2)) w2r_i (
        .clk (rd_clk),
        .rst_n(rd_rst_n),
        .din (wr_gray),
        .dout(wgray_at_rd)
    );

    cdc_fifo_sync #(.W(PW), .STAGES(2)) r2w_i (
        .clk (wr_clk),
        .rst_n(wr_rst_n),
        .din (rd_gray),
        .dout(rgray_at_wr)
    );

    cdc_fifo_wside #(.PW(PW), .DEPTH(DEPTH)) wside_i (
        .clk       (wr_clk),
        .rst_n     (wr_rst_n),
        .req       (wr_req),
        .rgray_sync(rgray_at_wr),
        .full      (wr_full),
        .wen       (wr_en),
        .ptr       (wr_ptr),
        .gray      (wr_gray)
    );

    cdc_fifo_rside #(.PW(PW)) rside_i (
        .clk       (rd_clk),
        .rst_n     (rd_rst_n),
        .req       (rd_req),
        .wgray_sync(wgray_at_rd),
        .empty     (rd_empty),
        .ren       (rd_en),
        .valid     (rd_valid),
        .ptr       (rd_ptr),
        .gray      (rd_gray)
    );

    cdc_fifo_mem #(.DW(DW), .AW(AW)) mem_i (
        .wclk (wr_clk),
        .we   (wr_en),
        .waddr(wr_ptr[AW-1:0]),
        .wdata(wr_data),
        .rclk (rd_clk),
        .re   (rd_en),
        .raddr(rd_ptr[AW-1:0]),
        .rdata(rd_data)
    );
endmodule

// File: rtl/cdc_fifo_chk.sv
module cdc_fifo_chk #(
    parameter int PW = 5
) (
    input logic          wr_clk,
    input logic          wr_rst_n,
    input logic          wr_full,
    input logic [PW-1:0] wr_ptr,
    input logic [PW-1:0] wr_gray,
    input logic          rd_clk,
    input logic          rd_rst_n,
    input logic          rd_req,
    input logic          rd_empty,
    input logic          rd_valid,
    input logic [PW-1:0] rd_ptr,
    input logic [PW-1:0] rd_gray
);
    assert_full_holds_wptr_R4: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        wr_full |=> (wr_ptr == $past(wr_ptr)));

    assert_empty_holds_rptr_R5: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        rd_empty |=> (rd_ptr == $past(rd_ptr)));

    assert_valid_after_read_R6: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (rd_req && !rd_empty) |=> rd_valid);

    assert_no_valid_without_read_R6: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        !(rd_req && !rd_empty) |=> !rd_valid);

    assert_wgray_one_bit_R8: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        1'b1 |=> ($countones(wr_gray ^ $past(wr_gray)) <= 1));

    assert_rgray_one_bit_R8: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        1'b1 |=> ($countones(rd_gray ^ $past(rd_gray)) <= 1));
endmodule

bind cdc_fifo cdc_fifo_chk #(.PW(PW)) chk_i (
    .wr_clk  (wr_clk),
    .wr_rst_n(wr_rst_n),
    .wr_full (wr_full),
    .wr_ptr  (wr_ptr),
    .wr_gray (wr_gray),
    .rd_clk  (rd_clk),
    .rd_rst_n(rd_rst_n),
    .rd_req  (rd_req),
    .rd_empty(rd_empty),
    .rd_valid(rd_valid),
    .rd_ptr  (rd_ptr),
    .rd_gray (rd_gray)
);

// File: tb/cdc_fifo_tb_top.sv
module cdc_fifo_tb_top;
    localparam int DW        = 8;
    localparam int AW        = 4;
    localparam int DEPTH     = 1 << AW;
    localparam int WR_PERIOD = 10;
    localparam int RD_PERIOD = 17;

    logic          wr_clk = 1'b0, rd_clk = 1'b0;
    logic          wr_rst_n, rd_rst_n;
    logic          wr_req, rd_req;
    logic [DW-1:0] wr_data;
    logic          wr_full, rd_empty, rd_valid;
    logic [DW-1:0] rd_data;

    cdc_fifo #(.DW(DW), .AW(AW)) dut_i (
        .wr_clk  (wr_clk),
        .wr_rst_n(wr_rst_n),
        .wr_req  (wr_req),
        .wr_data (wr_data),
        .wr_full (wr_full),
        .rd_clk  (rd_clk),
        .rd_rst_n(rd_rst_n),
        .rd_req  (rd_req),
        .rd_empty(rd_empty),
        .rd_valid(rd_valid),
        .rd_data (rd_data)
    );

    initial forever #(WR_PERIOD / 2) wr_clk = ~wr_clk;
    initial forever begin
        #(RD_PERIOD / 2) rd_clk = 1'b1;
        #(RD_PERIOD - RD_PERIOD / 2) rd_clk = 1'b0;
    end

    int          checks = 0, errors = 0;
    logic [DW-1:0] sb[$];
    int          wr_acc = 0, rd_acc = 0, pops = 0;
    int          wr_mode = 0, rd_mode = 0;
    int          wr_duty = 0, rd_duty = 0;
    int unsigned wseed = 32'h1234_5678, rseed = 32'h0bad_cafe;
    bit          fill_check = 0;
    bit          finished = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // writer driver: decides requests at the falling edge; flags are stable there
    initial begin
        logic [DW-1:0] wdat;
        bit            req;
        wdat   = '0;
        wr_req = 1'b0;
        wr_data = '0;
        forever begin
            @(negedge wr_clk);
            if (!wr_rst_n) begin
                wr_req = 1'b0;
                continue;
            end
            if (fill_check)  // R3: full exactly at 16 outstanding words
                chk(wr_full == ((wr_acc - rd_acc) >= DEPTH), "R3", int'(wr_full),
                    int'((wr_acc - rd_acc) >= DEPTH));
            case (wr_mode)
                1:       req = 1'b1;
                2: begin
                    wseed = wseed * 32'd1103515245 + 32'd12345;
                    req   = ((wseed >> 16) % 100) < wr_duty;
                end
                3:       req = 1'b1;
                default: req = 1'b0;
            endcase
            wr_req  = req;
            wr_data = wdat;
            wdat    = wdat + 1'b1;
            if (req && !wr_full) begin
                sb.push_back(wr_data);
                wr_acc++;
                if (wr_mode == 3) wr_mode = 0;
                chk((wr_acc - rd_acc) <= DEPTH, "R9", wr_acc - rd_acc, DEPTH);
            end
        end
    end

    // reader driver and output monitor
    initial begin
        bit            req, exp_v, blocked;
        logic [DW-1:0] want;
        rd_req  = 1'b0;
        exp_v   = 1'b0;
        blocked = 1'b0;
        forever begin
            @(negedge rd_clk);
            if (!rd_rst_n) begin
                rd_req = 1'b0;
                exp_v  = 1'b0;
                continue;
            end
            chk(rd_valid == exp_v, blocked ? "R5" : "R6", int'(rd_valid), int'(exp_v));
            if (rd_valid) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R2", int'(rd_data), -1);
                end else begin
                    want = sb.pop_front();
                    pops++;
                    chk(rd_data == want, "R2", int'(rd_data), int'(want));
                end
            end
            case (rd_mode)
                1:       req = 1'b1;
                2: begin
                    rseed = rseed * 32'd1103515245 + 32'd12345;
                    req   = ((rseed >> 16) % 100) < rd_duty;
                end
                3:       req = 1'b1;
                default: req = 1'b0;
            endcase
            rd_req  = req;
            exp_v   = req && !rd_empty;
            blocked = req && rd_empty;
            if (exp_v) begin
                rd_acc++;
                if (rd_mode == 3) rd_mode = 0;
                chk((wr_acc - rd_acc) >= 0, "R9", wr_acc - rd_acc, 0);
            end
        end
    end

    task automatic drain();
        rd_mode = 1;
        while (sb.size() != 0) @(negedge rd_clk);
        repeat (12) @(negedge rd_clk);  // idle requests on an empty FIFO
        rd_mode = 0;
        repeat (2) @(negedge rd_clk);
    endtask

    task automatic stream(input int wd, input int rd, input int n);
        int target;
        wr_duty = wd;
        rd_duty = rd;
        target  = wr_acc + n;
        wr_mode = 2;
        rd_mode = 2;
        wait (wr_acc >= target);
        wr_mode = 0;
        drain();
        chk(wr_acc == rd_acc, "R9", wr_acc - rd_acc, 0);
        chk(rd_empty == 1'b1, "R5", int'(rd_empty), 1);
    endtask

    initial begin
        int k, p0;
        wr_rst_n = 1'b0;
        rd_rst_n = 1'b0;
        repeat (3) @(negedge rd_clk);
        chk(rd_empty == 1'b1, "R1", int'(rd_empty), 1);
        chk(wr_full == 1'b0, "R1", int'(wr_full), 0);
        chk(rd_valid == 1'b0, "R1", int'(rd_valid), 0);
        @(negedge wr_clk) wr_rst_n = 1'b1;
        @(negedge rd_clk) rd_rst_n = 1'b1;
        repeat (10) @(negedge rd_clk);

        // R7: empty release after a single write
        wr_mode = 3;
        wait (wr_acc == 1);
        k = 0;
        do begin
            @(negedge rd_clk);
            k++;
        end while (rd_empty && k < 20);
        chk(k >= 2 && k <= 8, "R7", k, 8);
        drain();

        // R3 and R4: fill with the reader idle, keep pushing while full
        p0 = pops;
        fill_check = 1;
        wr_mode = 1;
        wait ((wr_acc - rd_acc) == DEPTH);
        repeat (20) @(negedge wr_clk);
        chk(wr_full == 1'b1, "R4", int'(wr_full), 1);
        wr_mode = 0;
        @(negedge wr_clk);
        fill_check = 0;

        // R7: full release after a single read
        rd_mode = 3;
        wait (rd_acc == 2);
        k = 0;
        do begin
            @(negedge wr_clk);
            k++;
        end while (wr_full && k < 30);
        chk(k >= 2 && k <= 12, "R7", k, 12);
        drain();
        chk((pops - p0) == DEPTH, "R4", pops - p0, DEPTH);

        // R9 and R2 under mixed traffic
        stream(90, 30, 400);
        stream(30, 90, 400);
        stream(100, 100, 400);
        stream(60, 55, 400);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(WR_PERIOD * 150000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule